// File: doc/BRIEF.md
# Write-back data cache with redundant-store squashing

This block is a direct-mapped, write-back data cache that sits between a CPU-side request port and a word-addressed backing memory that moves whole lines. Loads and byte-enabled stores arrive over a valid/ready handshake. A hit is resolved in one lookup cycle. A miss first writes back a dirty victim if there is one, then fetches the line, then replays the lookup.

Every store that reaches a resident line is examined before anything is written. The bytes the store enables are compared with the bytes already held at that word. When none of them would change, the store is squashed. The line is left untouched, a clean line stays clean, and the redundant store can never cause a later write-back. This suits buffers that are reset to zero over and over while most of their words are already zero. Two counters report how many stores were squashed and how many lines were written back.

A store miss allocates. The fetched line is installed clean, and the store then runs through the same compare-and-merge path as a hit. A store that matches the freshly fetched data therefore also leaves the line clean.

Top module: `ssq_cache`

## Requirements
- R1: After reset, req_ready is high, rsp_valid and mem_req_valid are low, both counters read zero and every line is invalid, so the first access to any address misses.
- R2: A load that hits returns the addressed word on rsp_rdata with rsp_valid high. Both appear on the first clock edge after the lookup cycle. A store never raises rsp_valid.
- R3: A load that misses fetches the full line from the backing memory and then returns the requested word from that line.
- R4: A store hit in which at least one enabled byte differs writes only the enabled bytes into the word, keeps every other byte of the line, and marks the line dirty. Byte enable bit b covers data bits 8b+7 down to 8b.
- R5: A store in which every enabled byte already matches, including a store with no byte enabled, is squashed. It changes neither the line data nor its dirty flag, and it increments squash_count by one.
- R6: A store miss fetches the whole line first, installs it clean, and then applies R4 or R5 to the fetched data.
- R7: A miss whose victim is valid and dirty writes the victim line back, with one mem_req_valid pulse that has mem_req_write high, before it requests the fill. A clean or invalid victim causes no memory write. wb_count increments once per write-back.
- R8: req_ready is low from the cycle after a request is accepted until that request completes. A hit completes after exactly one busy cycle; a miss is busy for longer.
- R9: Each memory request is a single-cycle pulse addressed by line (word address divided by the line size). The block waits for mem_rsp_valid before it continues, and it never has more than one request outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Store data |
| req_be | input | DATA_W/8 | Store byte enables |
| rsp_valid | output | 1 | Load data valid (one cycle) |
| rsp_rdata | output | DATA_W | Load data |
| mem_req_valid | output | 1 | Memory request pulse |
| mem_req_write | output | 1 | 1 = write-back, 0 = line fetch |
| mem_req_addr | output | ADDR_W-log2(WORDS_PER_LINE) | Line address |
| mem_req_wdata | output | DATA_W*WORDS_PER_LINE | Victim line data |
| mem_rsp_valid | input | 1 | Memory done (fetch data or write acknowledge) |
| mem_rsp_rdata | input | DATA_W*WORDS_PER_LINE | Fetched line |
| squash_count | output | CNT_W | Squashed stores, wraps |
| wb_count | output | CNT_W | Write-backs, wraps |

## Verification
The acceptance edge moves the block into lookup. The next edge finishes a hit: it raises rsp_valid, updates the line and the squash counter, and raises req_ready again in the same cycle. A miss adds the write-back and fill round trips, each set by the memory latency, and then a second lookup. The bench therefore waits on falling edges until req_ready returns after each request. It reads the response, both counters and the number of busy cycles at that one falling edge, where every effect of the request has already settled. Whether a line stayed clean is checked at the ports by later conflicting misses, which either do or do not produce a write-back.

// File: rtl/ssq_pkg.sv
package ssq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOOKUP,
      ST_WB_REQ,
      ST_WB_WAIT,
      ST_FILL_REQ,
      ST_FILL_WAIT
   } ssq_state_e;

endpackage

// File: rtl/ssq_line_array.sv
module ssq_line_array #(
   parameter int LINES  = 8,
   parameter int IDX_W  = 3,
   parameter int TAG_W  = 5,
   parameter int LINE_W = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  idx,
   input  logic              fill_en,
   input  logic [TAG_W-1:0]  fill_tag,
   input  logic [LINE_W-1:0] fill_data,
   input  logic              wr_en,
   input  logic [LINE_W-1:0] wr_data,
   output logic              rd_valid,
   output logic              rd_dirty,
   output logic [TAG_W-1:0]  rd_tag,
   output logic [LINE_W-1:0] rd_data,
   output logic [LINES-1:0]  dirty_vec
);

   logic [LINES-1:0]  valid_q;
   logic [LINES-1:0]  dirty_q;
   logic [TAG_W-1:0]  tag_q  [LINES];
   logic [LINE_W-1:0] data_q [LINES];

   initial begin
      assert (LINES == (1 << IDX_W)) else $error("LINES must equal 2**IDX_W");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
         dirty_q <= '0;
      end else if (fill_en) begin
         valid_q[idx] <= 1'b1;
         dirty_q[idx] <= 1'b0;
      end else if (wr_en) begin
         dirty_q[idx] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (fill_en) begin
         tag_q[idx]  <= fill_tag;
         data_q[idx] <= fill_data;
      end else if (wr_en) begin
         data_q[idx] <= wr_data;
      end
   end

   assign rd_valid  = valid_q[idx];
   assign rd_dirty  = dirty_q[idx];
   assign rd_tag    = tag_q[idx];
   assign rd_data   = data_q[idx];
   assign dirty_vec = dirty_q;

   AST_FILL_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(fill_en && wr_en)); // R4

   AST_FILL_LEAVES_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      fill_en |=> (rd_valid && !rd_dirty)); // R6

endmodule

// File: rtl/ssq_byte_merge.sv
module ssq_byte_merge #(
   parameter int BYTES = 4
) (
   input  logic [8*BYTES-1:0] old_word,
   input  logic [8*BYTES-1:0] new_word,
   input  logic [BYTES-1:0]   be,
   output logic [8*BYTES-1:0] merged,
   output logic               silent
);

   logic [BYTES-1:0] differs;

   initial begin
      assert (BYTES >= 1) else $error("BYTES must be at least 1");
   end

   for (genvar b = 0; b < BYTES; b++) begin : g_byte
      assign differs[b]        = be[b] && (old_word[8*b +: 8] != new_word[8*b +: 8]);
      assign merged[8*b +: 8]  = be[b] ? new_word[8*b +: 8] : old_word[8*b +: 8];
   end

   assign silent = ~|differs;

endmodule

// File: rtl/ssq_cache.sv
module ssq_cache
   import ssq_pkg::*;
#(
   parameter int ADDR_W         = 10,
   parameter int DATA_W         = 32,
   parameter int WORDS_PER_LINE = 4,
   parameter int LINES          = 8,
   parameter int CNT_W          = 16,
   localparam int BYTES   = DATA_W / 8,
   localparam int OFF_W   = $clog2(WORDS_PER_LINE),
   localparam int IDX_W   = $clog2(LINES),
   localparam int TAG_W   = ADDR_W - OFF_W - IDX_W,
   localparam int LADDR_W = ADDR_W - OFF_W,
   localparam int LINE_W  = DATA_W * WORDS_PER_LINE
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic               req_write,
   input  logic [ADDR_W-1:0]  req_addr,
   input  logic [DATA_W-1:0]  req_wdata,
   input  logic [BYTES-1:0]   req_be,
   output logic               rsp_valid,
   output logic [DATA_W-1:0]  rsp_rdata,
   output logic               mem_req_valid,
   output logic               mem_req_write,
   output logic [LADDR_W-1:0] mem_req_addr,
   output logic [LINE_W-1:0]  mem_req_wdata,
   input  logic               mem_rsp_valid,
   input  logic [LINE_W-1:0]  mem_rsp_rdata,
   output logic [CNT_W-1:0]   squash_count,
   output logic [CNT_W-1:0]   wb_count
);

   initial begin
      assert (DATA_W % 8 == 0) else $error("DATA_W must be a whole number of bytes");
      assert (WORDS_PER_LINE >= 2 && (WORDS_PER_LINE & (WORDS_PER_LINE - 1)) == 0)
         else $error("WORDS_PER_LINE must be a power of two, at least 2");
      assert (LINES >= 2 && (LINES & (LINES - 1)) == 0)
         else $error("LINES must be a power of two, at least 2");
      assert (TAG_W >= 1) else $error("ADDR_W too small for the geometry");
   end

   ssq_state_e         state_q, state_d;
   logic               r_write;
   logic [TAG_W-1:0]   r_tag;
   logic [IDX_W-1:0]   r_idx;
   logic [OFF_W-1:0]   r_off;
   logic [DATA_W-1:0]  r_wdata;
   logic [BYTES-1:0]   r_be;
   logic               rsp_valid_q;
   logic [DATA_W-1:0]  rsp_rdata_q;
   logic [CNT_W-1:0]   squash_q;
   logic [CNT_W-1:0]   wb_q;

   logic               rd_valid, rd_dirty;
   logic [TAG_W-1:0]   rd_tag;
   logic [LINE_W-1:0]  rd_data;
   logic [LINES-1:0]   dirty_vec;
   logic [DATA_W-1:0]  old_word, merged_word;
   logic               silent;
   logic [LINE_W-1:0]  new_line;
   logic               lookup_hit, store_wr, store_sq, fill_en, accept;

   assign accept     = req_valid && req_ready;
   assign lookup_hit = (state_q == ST_LOOKUP) && rd_valid && (rd_tag == r_tag);
   assign store_wr   = lookup_hit && r_write && !silent;
   assign store_sq   = lookup_hit && r_write && silent;
   assign fill_en    = (state_q == ST_FILL_WAIT) && mem_rsp_valid;
   assign old_word   = rd_data[DATA_W*r_off +: DATA_W];

   always_comb begin
      new_line = rd_data;
      new_line[DATA_W*r_off +: DATA_W] = merged_word;
   end

   ssq_line_array #(
      .LINES (LINES),
      .IDX_W (IDX_W),
      .TAG_W (TAG_W),
      .LINE_W(LINE_W)
   ) u_lines (
      .clk      (clk),
      .rst_n    (rst_n),
      .idx      (r_idx),
      .fill_en  (fill_en),
      .fill_tag (r_tag),
      .fill_data(mem_rsp_rdata),
      .wr_en    (store_wr),
      .wr_data  (new_line),
      .rd_valid (rd_valid),
      .rd_dirty (rd_dirty),
      .rd_tag   (rd_tag),
      .rd_data  (rd_data),
      .dirty_vec(dirty_vec)
   );

   ssq_byte_merge #(
      .BYTES(BYTES)
   ) u_merge (
      .old_word(old_word),
      .new_word(r_wdata),
      .be      (r_be),
      .merged  (merged_word),
      .silent  (silent)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:      if (req_valid) state_d = ST_LOOKUP;
         ST_LOOKUP: begin
            if (lookup_hit)                state_d = ST_IDLE;
            else if (rd_valid && rd_dirty) state_d = ST_WB_REQ;
            else                           state_d = ST_FILL_REQ;
         end
         ST_WB_REQ:    state_d = ST_WB_WAIT;
         ST_WB_WAIT:   if (mem_rsp_valid) state_d = ST_FILL_REQ;
         ST_FILL_REQ:  state_d = ST_FILL_WAIT;
         ST_FILL_WAIT: if (mem_rsp_valid) state_d = ST_LOOKUP;
         default:      state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         rsp_valid_q <= 1'b0;
         rsp_rdata_q <= '0;
         squash_q    <= '0;
         wb_q        <= '0;
      end else begin
         state_q     <= state_d;
         rsp_valid_q <= lookup_hit && !r_write;
         if (lookup_hit && !r_write) rsp_rdata_q <= old_word;
         if (store_sq) squash_q <= squash_q + 1'b1;
         if (state_q == ST_WB_REQ) wb_q <= wb_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (accept) begin
         r_write <= req_write;
         r_tag   <= req_addr[ADDR_W-1 -: TAG_W];
         r_idx   <= req_addr[OFF_W +: IDX_W];
         r_off   <= req_addr[OFF_W-1:0];
         r_wdata <= req_wdata;
         r_be    <= req_be;
      end
   end

   assign req_ready     = (state_q == ST_IDLE);
   assign rsp_valid     = rsp_valid_q;
   assign rsp_rdata     = rsp_rdata_q;
   assign mem_req_valid = (state_q == ST_WB_REQ) || (state_q == ST_FILL_REQ);
   assign mem_req_write = (state_q == ST_WB_REQ);
   assign mem_req_addr  = (state_q == ST_WB_REQ) ? {rd_tag, r_idx} : {r_tag, r_idx};
   assign mem_req_wdata = rd_data;
   assign squash_count  = squash_q;
   assign wb_count      = wb_q;

   AST_READY_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !req_ready); // R8

   AST_MEM_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |=> !mem_req_valid); // R9

   AST_WB_ONLY_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && mem_req_write) |-> dirty_vec[r_idx]); // R7

   AST_SQUASH_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      store_sq |=> $stable(dirty_vec)); // R5

   AST_SQUASH_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      store_sq |=> (squash_count == $past(squash_count) + 1'b1)); // R5

   AST_RSP_AFTER_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(state_q == ST_LOOKUP)); // R2

   AST_IDLE_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !mem_req_valid); // R9

endmodule

// File: tb/ssq_cache_tb_top.sv
module ssq_cache_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int MEM_LAT    = 3;
   localparam int NV         = 17;

   typedef struct packed {
      logic        wr;
      logic [9:0]  addr;
      logic [31:0] data;
      logic [3:0]  be;
      logic [31:0] exp;
      logic [7:0]  sq;
      logic [7:0]  wb;
      logic        hit;
   } vec_t;

   // Word address bits: [1:0] word in line, [4:2] line index, [9:5] tag.
   // Memory word i initially holds the value i.
   localparam vec_t VECS [NV] = '{
      '{1'b0, 10'h001, 32'h0,        4'h0, 32'h00000001, 8'd0, 8'd0, 1'b0},
      '{1'b1, 10'h001, 32'h00000001, 4'hF, 32'h0,        8'd1, 8'd0, 1'b1},
      '{1'b1, 10'h002, 32'h00000002, 4'h1, 32'h0,        8'd2, 8'd0, 1'b1},
      '{1'b0, 10'h020, 32'h0,        4'h0, 32'h00000020, 8'd2, 8'd0, 1'b0},
      '{1'b0, 10'h001, 32'h0,        4'h0, 32'h00000001, 8'd2, 8'd0, 1'b0},
      '{1'b1, 10'h003, 32'h000000FF, 4'h1, 32'h0,        8'd2, 8'd0, 1'b1},
      '{1'b0, 10'h003, 32'h0,        4'h0, 32'h000000FF, 8'd2, 8'd0, 1'b1},
      '{1'b1, 10'h003, 32'hAABBCCFF, 4'h1, 32'h0,        8'd3, 8'd0, 1'b1},
      '{1'b0, 10'h003, 32'h0,        4'h0, 32'h000000FF, 8'd3, 8'd0, 1'b1},
      '{1'b0, 10'h023, 32'h0,        4'h0, 32'h00000023, 8'd3, 8'd1, 1'b0},
      '{1'b0, 10'h003, 32'h0,        4'h0, 32'h000000FF, 8'd3, 8'd1, 1'b0},
      '{1'b1, 10'h045, 32'h11223344, 4'h6, 32'h0,        8'd3, 8'd1, 1'b0},
      '{1'b0, 10'h045, 32'h0,        4'h0, 32'h00223345, 8'd3, 8'd1, 1'b1},
      '{1'b1, 10'h065, 32'h00000065, 4'hF, 32'h0,        8'd4, 8'd2, 1'b0},
      '{1'b0, 10'h045, 32'h0,        4'h0, 32'h00223345, 8'd4, 8'd2, 1'b0},
      '{1'b1, 10'h045, 32'h0,        4'h0, 32'h0,        8'd5, 8'd2, 1'b1},
      '{1'b0, 10'h065, 32'h0,        4'h0, 32'h00000065, 8'd5, 8'd2, 1'b0}
   };

   logic         clk, rst_n;
   logic         req_valid, req_ready, req_write;
   logic [9:0]   req_addr;
   logic [31:0]  req_wdata;
   logic [3:0]   req_be;
   logic         rsp_valid;
   logic [31:0]  rsp_rdata;
   logic         mem_req_valid, mem_req_write;
   logic [7:0]   mem_req_addr;
   logic [127:0] mem_req_wdata;
   logic         mem_rsp_valid;
   logic [127:0] mem_rsp_rdata;
   logic [15:0]  squash_count, wb_count;

   int checks = 0;
   int errors = 0;
   int mem_writes = 0;
   int pulse_bad = 0;
   logic [31:0] mem [1024];

   ssq_cache dut_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
      .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
      .squash_count(squash_count), .wb_count(wb_count)
   );

   initial begin
      clk = 1'b0;
      forever #(CLK_PERIOD / 2) clk = ~clk;
   end

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Backing memory: fixed latency, one request at a time, sampled on falling edges.
   initial begin
      int pend;
      logic [7:0] laddr;
      logic prev_req;
      pend = 0;
      laddr = '0;
      prev_req = 1'b0;
      for (int i = 0; i < 1024; i++) mem[i] = i;
      mem_rsp_valid = 1'b0;
      mem_rsp_rdata = '0;
      forever begin
         @(negedge clk);
         mem_rsp_valid = 1'b0;
         if (mem_req_valid && prev_req) pulse_bad++;
         prev_req = mem_req_valid;
         if (pend > 0) begin
            pend--;
            if (pend == 0) begin
               mem_rsp_valid = 1'b1;
               for (int w = 0; w < 4; w++) mem_rsp_rdata[32*w +: 32] = mem[int'(laddr)*4 + w];
            end
         end else if (mem_req_valid) begin
            laddr = mem_req_addr;
            if (mem_req_write) begin
               mem_writes++;
               for (int w = 0; w < 4; w++) mem[int'(laddr)*4 + w] = mem_req_wdata[32*w +: 32];
            end
            pend = MEM_LAT;
         end
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   task automatic do_op(input vec_t v, output logic [31:0] rd, output bit got,
                        output int busy);
      int guard;
      guard = 0;
      @(negedge clk);
      while (!req_ready && guard < 500) begin @(negedge clk); guard++; end
      req_valid = 1'b1;
      req_write = v.wr;
      req_addr  = v.addr;
      req_wdata = v.data;
      req_be    = v.be;
      @(negedge clk);
      req_valid = 1'b0;
      busy = 0;
      while (!req_ready && busy < 500) begin busy++; @(negedge clk); end
      got = rsp_valid;
      rd  = rsp_rdata;
   endtask

   initial begin
      logic [31:0] rd;
      bit got;
      int busy;
      rst_n = 1'b0;
      req_valid = 1'b0;
      req_write = 1'b0;
      req_addr = '0;
      req_wdata = '0;
      req_be = '0;
      repeat (3) @(negedge clk);
      // R1: reset state
      check(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 32'd1);
      check(rsp_valid == 1'b0, "R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
      check(mem_req_valid == 1'b0, "R1 mem_req_valid after reset", 32'(mem_req_valid), 32'd0);
      check(squash_count == 16'd0 && wb_count == 16'd0, "R1 counters after reset",
            {squash_count, wb_count}, 32'd0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         do_op(VECS[i], rd, got, busy);
         // R8: a hit takes one busy cycle, a miss more (first access shows R1 invalid lines)
         check(((busy == 1) == VECS[i].hit) && busy < 500, "R8 R1 busy cycles",
               32'(busy), 32'(VECS[i].hit));
         // R2: responses only for loads
         check(got == !VECS[i].wr, "R2 response flag", 32'(got), 32'(!VECS[i].wr));
         if (!VECS[i].wr)
            check(rd == VECS[i].exp, "R2 R3 R4 R6 load data", rd, VECS[i].exp);
         check(squash_count == 16'(VECS[i].sq), "R5 R6 squash_count",
               32'(squash_count), 32'(VECS[i].sq));
         check(wb_count == 16'(VECS[i].wb), "R7 wb_count", 32'(wb_count), 32'(VECS[i].wb));
      end

      repeat (2) @(negedge clk);
      check(mem_writes == int'(wb_count), "R7 memory writes vs wb_count",
            32'(mem_writes), 32'(wb_count));
      check(mem[32'h045] == 32'h00223345, "R4 R7 written-back merged word",
            mem[32'h045], 32'h00223345);
      check(mem[32'h003] == 32'h000000FF, "R7 first write-back word",
            mem[32'h003], 32'h000000FF);
      check(pulse_bad == 0, "R9 single-cycle memory pulses", 32'(pulse_bad), 32'd0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule